// File: doc/BRIEF.md
# Biphase Bit-Cell Modulator

This block turns a serial bit stream into the control signal for a load modulator in a field-powered tag. It is clocked by the system clock, and `carrier_tick` qualifies the edges. Each qualified tick is one period of the carrier. Every bit takes a cell of a fixed number of ticks. The output level flips at the start of every cell. A "1" keeps that level for the rest of the cell. A "0" flips the level once more at half-cell.

The block asks the frame source for a bit with a one-cycle request. It takes the bit in that same cycle, so the upstream source needs no buffer. The output `mod_n` is active low: 0 means the modulator draws current (ON) and 1 means it is released (OFF).

An optional advance mode lets the ON-to-OFF edge happen a few ticks early. This trims the falling tail of the field response. OFF-to-ON edges never move.

Top module: `biphase_cell_modulator`

## Requirements
- R1: A cell lasts exactly 32 asserted `carrier_tick` cycles, and consecutive cell boundaries are 32 ticks apart.
- R2: While `rst_n` is low at a clock edge, the block resets: `mod_n` becomes 1 (OFF), and `bit_req` stays 0 until the next tick. The first tick after reset is a cell boundary.
- R3: At every cell boundary the nominal output level flips, so the level after the boundary tick is the inverse of the level before it.
- R4: A "1" cell holds its level for all 32 ticks. A "0" cell flips the level again after its 16th tick.
- R5: `bit_req` is high only in a cycle where `carrier_tick` is high and the cell position is its last (tick count 31, or the first tick after reset). `data_bit` is sampled at the end of that cycle and has no effect in any other cycle.
- R6: With `adv_en` low, or with an advance of 0, `mod_n` follows the nominal level exactly. A 0 on `mod_n` means modulation ON.
- R7: With `adv_en` high, the advance is A = min(`adv_clks`, 8). Every 0-to-1 edge of `mod_n` (ON to OFF) happens A ticks before its nominal tick. Every 1-to-0 edge stays at its nominal tick.
- R8: The advance setting is captured on the boundary tick of each cell. Changes to `adv_en` or `adv_clks` during a cell take effect only at the next cell.
- R9: In a cycle without `carrier_tick`, neither `mod_n` nor the cell position changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| carrier_tick | input | 1 | One carrier period has elapsed; qualifies all state updates |
| data_bit | input | 1 | Next bit from the frame source, valid in cycles where `bit_req` is high |
| bit_req | output | 1 | The next bit is taken in this cycle |
| adv_en | input | 1 | Enable the early release of ON-to-OFF edges |
| adv_clks | input | 4 | Requested advance in ticks, saturated at 8 |
| mod_n | output | 1 | Modulator control, 0 = draw current (ON) |

## Verification
The bench compares against a tick-accurate model and goes after these errors:
- An off-by-one in the cell or half-cell count. This would drift every later edge by a tick.
- A request raised one tick late, or a bit taken outside the request. The bench drives random junk on `data_bit` between requests to expose this, and a late or wrong capture would show as a wrong level.
- An advance applied to OFF-to-ON edges, or left unsaturated above 8. This would pull the wrong edges forward, or release a "0" cell's ON half too early.
- Setting changes mid-cell and gapped tick patterns. These catch a design that reads the advance live, or that counts clocks instead of ticks.

// File: rtl/bpm_pkg.sv
// Package: shared encodings for the biphase cell modulator.
// Assumes the modulator output is active low (0 = load on).
package bpm_pkg;

    // Level driven on the modulator control line.
    localparam logic LVL_OFF = 1'b1;
    localparam logic LVL_ON  = 1'b0;

    // Saturate a requested advance to the allowed maximum.
    function automatic logic [3:0] sat_adv(input logic [3:0] req, input logic [3:0] lim);
        return (req > lim) ? lim : req;
    endfunction

endpackage

// File: rtl/bpm_cell_timer.sv
// Module: bpm_cell_timer
// Counts carrier ticks within a bit cell and flags the boundary and
// half-cell ticks. Assumes CELL_CLKS is even and at least 4. The count
// resets to the last position so that the first tick after reset is
// a boundary.
module bpm_cell_timer #(
    parameter int CELL_CLKS = 32,
    localparam int CNT_W    = $clog2(CELL_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic             boundary,
    output logic             mid,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] nxt_cnt
);

    localparam logic [CNT_W-1:0] LAST  = CNT_W'(CELL_CLKS - 1);
    localparam logic [CNT_W-1:0] HLAST = CNT_W'(CELL_CLKS / 2 - 1);

    logic [CNT_W-1:0] cnt_q;

    // Decode the ticks that end a cell or a half-cell.
    always_comb begin
        boundary = tick && (cnt_q == LAST);
        mid      = tick && (cnt_q == HLAST);
    end

    // Next count: wrap at the cell end, hold without a tick.
    always_comb begin
        nxt_cnt = cnt_q;
        if (tick) begin
            nxt_cnt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Count register, parked on the last position after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LAST;
        end else begin
            cnt_q <= nxt_cnt;
        end
    end

    assign cnt = cnt_q;

    // R9: the position never moves in a cycle without a tick.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

    // R1: a boundary tick always starts the new cell at position zero.
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (cnt_q == '0));

endmodule

// File: rtl/bpm_level_coder.sv
// Module: bpm_level_coder
// Holds the bit of the current cell and the nominal biphase level.
// It flips the level on every boundary tick, and on the half-cell tick
// when the cell carries a zero. It assumes that boundary and mid are
// never high together.
module bpm_level_coder
    import bpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boundary,
    input  logic mid,
    input  logic data_bit,
    output logic lvl,
    output logic nxt_lvl,
    output logic nxt_bit
);

    logic lvl_q;
    logic bit_q;

    // Next level and bit: take a new bit and flip on a boundary, flip a zero at half-cell.
    always_comb begin
        nxt_lvl = lvl_q;
        nxt_bit = bit_q;
        if (boundary) begin
            nxt_lvl = ~lvl_q;
            nxt_bit = data_bit;
        end else if (mid && !bit_q) begin
            nxt_lvl = ~lvl_q;
        end
    end

    // Level and bit registers, released (OFF) after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LVL_OFF;
            bit_q <= 1'b1;
        end else begin
            lvl_q <= nxt_lvl;
            bit_q <= nxt_bit;
        end
    end

    assign lvl = lvl_q;

    // R3: every boundary inverts the level.
    p_boundary_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (lvl_q != $past(lvl_q)));

    // R4: a one-cell keeps its level through the half-cell tick.
    p_one_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mid && bit_q) |=> $stable(lvl_q));

    // R4: a zero-cell inverts at the half-cell tick.
    p_zero_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mid && !bit_q) |=> (lvl_q != $past(lvl_q)));

endmodule

// File: rtl/bpm_release_advance.sv
// Module: bpm_release_advance
// Registers the modulator control line. When the line is ON and the next
// nominal edge (half-cell for a zero in its first half, otherwise the cell
// end) is within the captured advance, it releases the line early. It
// assumes ADV_MAX is below half a cell, so the advance never crosses into
// the previous edge. ADV_SUPPORT = 0 builds the variant without advance.
module bpm_release_advance
    import bpm_pkg::*;
#(
    parameter int CELL_CLKS   = 32,
    parameter int ADV_W       = 4,
    parameter int ADV_MAX     = 8,
    parameter bit ADV_SUPPORT = 1'b1,
    localparam int CNT_W      = $clog2(CELL_CLKS),
    localparam int SUM_W      = $clog2(CELL_CLKS + ADV_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             adv_en,
    input  logic [ADV_W-1:0] adv_clks,
    input  logic [CNT_W-1:0] nxt_cnt,
    input  logic             nxt_lvl,
    input  logic             nxt_bit,
    input  logic             lvl,
    output logic             mod_n
);

    localparam logic [SUM_W-1:0] HALF_S = SUM_W'(CELL_CLKS / 2);
    localparam logic [SUM_W-1:0] CELL_S = SUM_W'(CELL_CLKS);
    localparam logic [ADV_W-1:0] LIM    = ADV_W'(ADV_MAX);

    logic [ADV_W-1:0] adv_q;
    logic [ADV_W-1:0] nxt_adv;
    logic [SUM_W-1:0] edge_pos;
    logic [SUM_W-1:0] reach;
    logic             early;
    logic             mod_q;

    generate
        if (ADV_SUPPORT) begin : g_adv
            // Capture the saturated advance on each boundary tick.
            always_comb begin
                nxt_adv = adv_q;
                if (boundary) begin
                    nxt_adv = adv_en ? ADV_W'(sat_adv(4'(adv_clks), 4'(LIM))) : '0;
                end
            end
        end else begin : g_noadv
            // The variant without advance: the captured amount is always zero.
            always_comb begin
                nxt_adv = '0;
            end
        end
    endgenerate

    // Find the next nominal edge and whether the next state lies in the early window.
    always_comb begin
        edge_pos = (!nxt_bit && (SUM_W'(nxt_cnt) < HALF_S)) ? HALF_S : CELL_S;
        reach    = SUM_W'(nxt_cnt) + SUM_W'(nxt_adv);
        early    = (nxt_lvl == LVL_ON) && (nxt_adv != '0) && (reach >= edge_pos);
    end

    // Registered control line and the advance captured for the current cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= LVL_OFF;
            adv_q <= '0;
        end else begin
            mod_q <= early ? LVL_OFF : nxt_lvl;
            adv_q <= nxt_adv;
        end
    end

    assign mod_n = mod_q;

    // R7: the output is never ON while the nominal level is OFF.
    p_off_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LVL_OFF) |-> (mod_q == LVL_OFF));

    // R7: an OFF-to-ON edge occurs only together with the nominal one.
    p_on_edge_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_q) |-> $fell(lvl));

    // R6: with no advance captured, the output equals the nominal level.
    p_no_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_q == '0) |-> (mod_q == lvl));

    // R8: the captured advance changes only on boundary ticks.
    p_adv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(adv_q));

endmodule

// File: rtl/biphase_cell_modulator.sv
// Module: biphase_cell_modulator (top)
// Biphase bit-cell modulator. It is timed only by carrier ticks, requests
// one bit per cell and drives an active-low modulator control line with an
// optional early release of ON-to-OFF edges. It assumes the source presents
// data_bit in the same cycle that bit_req is high.
module biphase_cell_modulator #(
    parameter int CELL_CLKS   = 32,
    parameter int ADV_W       = 4,
    parameter int ADV_MAX     = 8,
    parameter bit ADV_SUPPORT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carrier_tick,
    input  logic             data_bit,
    output logic             bit_req,
    input  logic             adv_en,
    input  logic [ADV_W-1:0] adv_clks,
    output logic             mod_n
);

    localparam int CNT_W = $clog2(CELL_CLKS);

    logic             boundary;
    logic             mid;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt_cnt;
    logic             lvl;
    logic             nxt_lvl;
    logic             nxt_bit;

    // Cell position and the boundary and half-cell strobes.
    bpm_cell_timer #(.CELL_CLKS(CELL_CLKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (carrier_tick),
        .boundary (boundary),
        .mid      (mid),
        .cnt      (cnt),
        .nxt_cnt  (nxt_cnt)
    );

    // Nominal biphase level.
    bpm_level_coder u_coder (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .mid      (mid),
        .data_bit (data_bit),
        .lvl      (lvl),
        .nxt_lvl  (nxt_lvl),
        .nxt_bit  (nxt_bit)
    );

    // Early release and the output register.
    bpm_release_advance #(
        .CELL_CLKS   (CELL_CLKS),
        .ADV_W       (ADV_W),
        .ADV_MAX     (ADV_MAX),
        .ADV_SUPPORT (ADV_SUPPORT)
    ) u_adv (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .adv_en   (adv_en),
        .adv_clks (adv_clks),
        .nxt_cnt  (nxt_cnt),
        .nxt_lvl  (nxt_lvl),
        .nxt_bit  (nxt_bit),
        .lvl      (lvl),
        .mod_n    (mod_n)
    );

    // The request is the boundary tick: the bit is taken in that cycle.
    assign bit_req = boundary;

    // R5: a request is raised only on a tick.
    p_req_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req |-> carrier_tick);

    // R1: the cell position after a request is zero.
    p_req_starts_cell_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req |=> (cnt == '0));

endmodule

// File: tb/biphase_cell_modulator_test.sv
module biphase_cell_modulator_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       carrier_tick = 1'b0;
    logic       data_bit = 1'b0;
    logic       bit_req;
    logic       adv_en = 1'b0;
    logic [3:0] adv_clks = 4'd0;
    logic       mod_n;

    biphase_cell_modulator uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .carrier_tick (carrier_tick),
        .data_bit     (data_bit),
        .bit_req      (bit_req),
        .adv_en       (adv_en),
        .adv_clks     (adv_clks),
        .mod_n        (mod_n)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int ticks = 0;
    bit done = 1'b0;
    bit prev_tick = 1'b1;
    logic [15:0] lfsr = 16'hACE1;
    bit cbit[0:511];
    int zpref[0:512];
    int acap[0:511];
    bit g_en = 1'b0;
    int g_amt = 0;

    task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at tick %0d", tag, act, exp, ticks);
        end
    endtask

    function automatic logic exp_mod();
        int k, c, p, tg, e;
        logic lv;
        if (ticks == 0) return 1'b1;
        k = ticks - 1;
        c = k / 32;
        p = k % 32;
        tg = (c + 1) + zpref[c] + ((cbit[c] == 1'b0 && p >= 16) ? 1 : 0);
        lv = (tg % 2 == 0);
        if (lv == 1'b0 && acap[c] > 0) begin
            e = (cbit[c] == 1'b0 && p < 16) ? 16 : 32;
            if (p >= e - acap[c]) return 1'b1;
        end
        return lv;
    endfunction

    task automatic step(input bit tk);
        bit bnd;
        int c;
        int satv;
        logic em;
        string tag;
        @(negedge clk);
        carrier_tick = tk;
        adv_en = g_en;
        adv_clks = 4'(g_amt);
        bnd = tk && (ticks % 32 == 0);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        data_bit = lfsr[0];
        #1;
        em = exp_mod();
        satv = g_en ? ((g_amt > 8) ? 8 : g_amt) : 0;
        if (!prev_tick) tag = "R9";
        else if (ticks > 0 && acap[(ticks - 1) / 32] != satv) tag = "R8";
        else if (ticks > 0 && acap[(ticks - 1) / 32] > 0) tag = "R7";
        else tag = "R3 R4 R6";
        chk(mod_n === em, tag, mod_n, em);
        chk(bit_req === bnd, "R1 R5 bit_req", bit_req, bnd);
        if (bnd) begin
            c = ticks / 32;
            cbit[c] = data_bit;
            zpref[c + 1] = zpref[c] + (data_bit ? 0 : 1);
            acap[c] = satv;
        end
        @(posedge clk);
        if (tk) ticks++;
        prev_tick = tk;
    endtask

    task automatic run_cells(input int ncells, input int gap);
        int target;
        int cyc = 0;
        target = ticks + ncells * 32;
        while (ticks < target) begin
            step((gap == 0) || (cyc % gap != 1));
            cyc++;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            carrier_tick = 1'b1;
            data_bit = 1'b0;
        end
        @(negedge clk);
        carrier_tick = 1'b0;
        rst_n = 1'b1;
        ticks = 0;
        zpref[0] = 0;
        prev_tick = 1'b1;
        #1;
        chk(mod_n === 1'b1, "R2 reset mod_n", mod_n, 1'b1);
        chk(bit_req === 1'b0, "R2 reset bit_req", bit_req, 1'b0);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(mod_n === 1'b1, "R2 idle after reset", mod_n, 1'b1);
        @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R3 R4 R6: no advance, tick every cycle
        g_en = 1'b0; g_amt = 0;
        run_cells(12, 0);
        // R7: small advance
        g_en = 1'b1; g_amt = 3;
        run_cells(8, 0);
        // R7 R9: full advance with gapped ticks
        g_amt = 8;
        run_cells(8, 3);
        // R7: request above the limit saturates to 8
        g_amt = 13;
        run_cells(6, 0);
        // R8: setting changes mid-cell
        begin
            int target;
            int cyc = 0;
            target = ticks + 10 * 32;
            while (ticks < target) begin
                if (cyc % 5 == 2) begin
                    g_amt = (g_amt + 7) % 16;
                    g_en = (cyc % 35 != 2);
                end
                step(cyc % 4 != 3);
                cyc++;
            end
        end
        // R6: amount present but advance disabled
        g_en = 1'b0; g_amt = 8;
        run_cells(4, 0);
        // R2: reset in mid-run, then restart
        do_reset();
        g_en = 1'b1; g_amt = 5;
        run_cells(3, 2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule